// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

This block is one timer channel that runs in interval mode. It runs on the system clock. It moves forward only on a one-cycle count-enable pulse (`tick`) that a prescaler outside the block supplies. Software writes a start strobe to arm the channel. The channel does not load its counter at that moment. It waits for the next count-enable pulse and treats it as the start trigger. On that pulse it copies the programmed period value into the counter and raises a one-cycle start pulse. If the start-interrupt mode is selected, it also raises the interrupt.

After the start, each count-enable pulse decrements the counter. A count-enable pulse that finds the counter at zero raises a one-cycle interrupt and reloads the period value, so the channel never stops by itself. The interval is therefore (period + 1) count clocks. The first interval can be up to one count clock longer than that, because the start waits for a count-enable pulse. The stop input returns the channel to idle and freezes the counter. A later start write re-arms it.

Top module: `rld_interval_timer`

## Requirements
- R1: After reset, `count` is 0, `running` is 0, and `irq` and `start_pulse` are both 0.
- R2: A `start_wr` strobe while idle makes `running` 1 from the next cycle on. Until a count-enable pulse arrives, `count` keeps its current value.
- R3: The first `tick` that arrives after `running` is 1 is the start trigger. One cycle after it, `start_pulse` is 1 and `count` equals the period register.
- R4: After the start trigger, each `tick` decrements `count` by one. In a cycle without `tick`, `count` does not change.
- R5: A `tick` that finds `count` at 0 reloads the period register into `count` and raises `irq` one cycle later. The interrupts therefore come every (period + 1) ticks, and with a period of 0 they come on every tick.
- R6: At the start trigger, `irq` is raised together with `start_pulse` when `mode_irq_start` is 1 in the trigger cycle. When it is 0, `irq` is not raised.
- R7: A `data_wr` write changes the period register only. It does not change `count`, and the new value is used at the next load or reload.
- R8: `stop` has priority over every other input. From the next cycle on, `running` is 0, `count` is frozen, and no `irq` or `start_pulse` follows, even when ticks keep arriving. A later start write re-arms the channel with a fresh start trigger.
- R9: A `start_wr` while `running` is 1 is ignored: it produces no `start_pulse` and does not disturb `count`.
- R10: A `tick` in the same cycle as the arming `start_wr` is not a start trigger.
- R11: `irq` and `start_pulse` are each high for exactly one clock cycle per event, and only in the cycle after a `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count-enable pulse |
| start_wr | input | 1 | Software start strobe |
| stop | input | 1 | Stop strobe; returns the channel to idle |
| mode_irq_start | input | 1 | 1 = also raise irq at the start trigger |
| data_wr | input | 1 | Write strobe for the period register |
| data_in | input | CNT_W | Period value to write |
| count | output | CNT_W | Current counter value |
| running | output | 1 | Channel armed or counting |
| start_pulse | output | 1 | Start-trigger detection pulse |
| irq | output | 1 | Interval interrupt pulse |

## Verification
Every result is registered exactly once, so each output is due in the cycle after the edge that samples the stimulus. `running` follows one cycle after a start or stop strobe. `count`, `start_pulse` and `irq` follow one cycle after the tick. The bench drives inputs on the falling edge, holds them for one full cycle, and reads the outputs at the next falling edge, which lies half a cycle after the edge where they change. After every tick it reads the outputs once more a cycle later, to confirm that the pulses have dropped and that the count stayed put. The sweep runs periods 0 to 5 in both start-interrupt modes over more than two full intervals. The expected count is (period minus the tick index modulo period+1).

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      TMR_IDLE  = 2'd0,
      TMR_ARMED = 2'd1,
      TMR_COUNT = 2'd2
   } tmr_state_e;

   localparam int unsigned TMR_MIN_W = 2;
   localparam int unsigned TMR_MAX_W = 32;
endpackage

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl
   import tmr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start_wr,
   input  logic stop,
   output logic trig,
   output logic step,
   output logic running
);
   tmr_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TMR_IDLE:  if (start_wr) st_d = TMR_ARMED;
         TMR_ARMED: if (tick)     st_d = TMR_COUNT;
         default:   ;
      endcase
      if (stop) st_d = TMR_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= TMR_IDLE;
      else        st_q <= st_d;
   end

   assign trig    = (st_q == TMR_ARMED) && tick && !stop;
   assign step    = (st_q == TMR_COUNT) && tick && !stop;
   assign running = (st_q != TMR_IDLE);
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] reload,
   output logic [W-1:0] count,
   output logic         wrap
);
   logic [W-1:0] cnt_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);
   assign wrap    = step && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load || wrap) cnt_q <= reload;
      else if (step)         cnt_q <= cnt_q - 1'b1;
   end

   assign count = cnt_q;
endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen #(
   parameter bit START_IRQ_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic wrap,
   input  logic mode_start,
   output logic irq,
   output logic start_pulse
);
   logic start_irq;

   if (START_IRQ_EN) begin : g_start_irq
      assign start_irq = trig & mode_start;
   end else begin : g_no_start_irq
      assign start_irq = trig & mode_start & 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq         <= 1'b0;
         start_pulse <= 1'b0;
      end else begin
         irq         <= wrap | start_irq;
         start_pulse <= trig;
      end
   end
endmodule

// File: rtl/rld_interval_timer.sv
module rld_interval_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter bit          START_IRQ_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start_wr,
   input  logic             stop,
   input  logic             mode_irq_start,
   input  logic             data_wr,
   input  logic [CNT_W-1:0] data_in,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             start_pulse,
   output logic             irq
);
   if (CNT_W < TMR_MIN_W || CNT_W > TMR_MAX_W) begin : g_bad_width
      $error("rld_interval_timer: CNT_W outside supported range");
   end

   logic [CNT_W-1:0] data_q;
   logic             trig, step, wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (data_wr) data_q <= data_in;
   end

   tmr_run_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_wr(start_wr),
      .stop(stop), .trig(trig), .step(step), .running(running)
   );

   tmr_down_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(trig), .step(step),
      .reload(data_q), .count(count), .wrap(wrap)
   );

   tmr_irq_gen #(.START_IRQ_EN(START_IRQ_EN)) u_irq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .wrap(wrap),
      .mode_start(mode_irq_start), .irq(irq), .start_pulse(start_pulse)
   );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int unsigned W            = 16,
   parameter bit          START_IRQ_EN = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         stop,
   input logic         mode_irq_start,
   input logic         irq,
   input logic         start_pulse,
   input logic         running,
   input logic [W-1:0] count,
   input logic [W-1:0] data_q
);
   // R4
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   // R8
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!running && !irq && !start_pulse));

   // R11
   irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick));

   // R11
   start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> ($past(tick) && $past(running)));

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (count == $past(data_q)));

   // R5
   wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !start_pulse) |-> (count == $past(data_q)));

   if (START_IRQ_EN) begin : g_mode_chk
      // R6
      start_irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         start_pulse |-> (irq == $past(mode_irq_start)));
   end
endmodule

bind rld_interval_timer tmr_chk #(.W(CNT_W), .START_IRQ_EN(START_IRQ_EN)) u_tmr_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop),
   .mode_irq_start(mode_irq_start), .irq(irq), .start_pulse(start_pulse),
   .running(running), .count(count), .data_q(data_q)
);

// File: tb/tb_rld_interval_timer.sv
`timescale 1ns/1ps
module tb_rld_interval_timer;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0, start_wr = 1'b0, stop = 1'b0;
   logic         mode_irq_start = 1'b0, data_wr = 1'b0;
   logic [W-1:0] data_in = '0;
   logic [W-1:0] count;
   logic         running, start_pulse, irq;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   rld_interval_timer #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_wr(start_wr), .stop(stop),
      .mode_irq_start(mode_irq_start), .data_wr(data_wr), .data_in(data_in),
      .count(count), .running(running), .start_pulse(start_pulse), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      tick = 0; start_wr = 0; stop = 0; data_wr = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic write_data(input int v);
      data_in = v[W-1:0]; data_wr = 1;
      @(negedge clk);
      data_wr = 0;
   endtask

   task automatic cycle(input bit t, input bit s, input bit p);
      tick = t; start_wr = s; stop = p;
      @(negedge clk);
      tick = 0; start_wr = 0; stop = 0;
   endtask

   // checks the pulses dropped and count held one cycle later
   task automatic idle_check(input string req);
      int c0;
      c0 = int'(count);
      @(negedge clk);
      chk(irq == 0, req, int'(irq), 0);
      chk(start_pulse == 0, req, int'(start_pulse), 0);
      chk(int'(count) == c0, req, int'(count), c0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(count == 0, "R1", int'(count), 0);
      chk(running == 0, "R1", int'(running), 0);
      chk(irq == 0 && start_pulse == 0, "R1", int'({irq, start_pulse}), 0);

      // R7 period write does not touch count
      write_data(6);
      chk(count == 0, "R7", int'(count), 0);

      // R10 tick together with arming start is not a trigger
      cycle(1, 1, 0);
      chk(running == 1, "R2", int'(running), 1);
      chk(start_pulse == 0, "R10", int'(start_pulse), 0);
      chk(count == 0, "R10", int'(count), 0);
      repeat (3) @(negedge clk);
      chk(count == 0, "R2", int'(count), 0);
      cycle(1, 0, 0);
      chk(start_pulse == 1, "R3", int'(start_pulse), 1);
      chk(count == 6, "R3", int'(count), 6);
      idle_check("R11");

      // sweep of periods and start-interrupt modes: R3 R4 R5 R6
      for (int m = 0; m < 2; m++) begin
         for (int d = 0; d <= 5; d++) begin
            do_reset();
            mode_irq_start = m[0];
            write_data(d);
            cycle(0, 1, 0);
            @(negedge clk);
            for (int j = 0; j <= 2 * (d + 1) + 1; j++) begin
               int  ec;
               bit  ei;
               ec = d - (j % (d + 1));
               ei = (j == 0) ? m[0] : (j % (d + 1) == 0);
               cycle(1, 0, 0);
               chk(int'(count) == ec, "R4", int'(count), ec);
               chk(irq == ei, (j == 0) ? "R6" : "R5", int'(irq), int'(ei));
               chk(start_pulse == (j == 0), "R3", int'(start_pulse), int'(j == 0));
               idle_check("R11");
            end
         end
      end

      // R7 new period takes effect only at reload
      do_reset();
      mode_irq_start = 0;
      write_data(3);
      cycle(0, 1, 0);
      cycle(1, 0, 0);
      chk(count == 3, "R3", int'(count), 3);
      write_data(7);
      chk(count == 3, "R7", int'(count), 3);
      for (int k = 0; k < 3; k++) cycle(1, 0, 0);
      chk(count == 0, "R7", int'(count), 0);
      cycle(1, 0, 0);
      chk(count == 7 && irq == 1, "R7", int'(count), 7);

      // R9 start write while running
      cycle(1, 1, 0);
      chk(start_pulse == 0, "R9", int'(start_pulse), 0);
      chk(count == 6, "R9", int'(count), 6);
      cycle(0, 1, 0);
      chk(start_pulse == 0 && count == 6, "R9", int'(count), 6);
      chk(running == 1, "R9", int'(running), 1);

      // R8 stop with a tick in the same cycle
      cycle(1, 0, 1);
      chk(running == 0, "R8", int'(running), 0);
      chk(count == 6 && irq == 0, "R8", int'(count), 6);
      for (int k = 0; k < 10; k++) begin
         cycle(1, 0, 0);
         chk(irq == 0 && start_pulse == 0 && count == 6, "R8", int'(count), 6);
      end
      // R8 restart gives a fresh trigger
      mode_irq_start = 1;
      cycle(0, 1, 0);
      cycle(1, 0, 0);
      chk(start_pulse == 1 && irq == 1, "R8", int'({start_pulse, irq}), 3);
      chk(count == 7, "R8", int'(count), 7);

      // R8 stop while armed, before any tick
      cycle(0, 0, 1);
      cycle(0, 1, 0);
      cycle(0, 0, 1);
      cycle(1, 0, 0);
      chk(start_pulse == 0 && running == 0, "R8", int'(start_pulse), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule